// File: doc/BRIEF.md
# Audio Sample Period Pacer

This block sets the pace of an audio processor that works in hard real time and has no sample queue between itself and the converters. A free-running cycle counter splits time into fixed sample periods. The default is 750 cycles, which gives a 48 kHz rate from a 36 MHz clock. When the program issues its output instruction, the block captures one packed stereo word for the converters. The upper byte of that word is the left channel and the lower byte is the right channel, each a signed 8-bit value. The block then holds the processor stalled until the next period begins.

The block also keeps two flags for the host. The interrupt flag is raised by a program instruction and can only be dropped by a host clear. The sticky underrun flag records that a whole period went by without any sample being emitted. In that case the converters keep the last value they were given.

Top module: `sample_pacer`

## Requirements
- R1: The period counter starts at zero in the first cycle after reset and wraps every PERIOD cycles. It runs the same way whether or not the stall is active, so period boundaries fall at fixed cycle counts from reset.
- R2: An accepted output request (outStrobe high while stall is low) makes dacLeft equal sampleIn[15:8] and dacRight equal sampleIn[7:0] in the next cycle.
- R3: dacStrobe is high for exactly one cycle for each accepted output request, in the cycle where the new converter values first appear, and is low at all other times.
- R4: After an accepted output request that is not in the final cycle of a period, stall is high from the next cycle up to and including the final cycle of that period.
- R5: stall is low in the first cycle of the period that follows the stalled one.
- R6: An output request made while stall is high is ignored: no strobe follows, and the converter values do not change.
- R7: If a period ends with no accepted output request, the converter values are held, and underrunFlag is high from the first cycle of the next period.
- R8: underrunFlag stays high until an underrunClr pulse, which drops it in the next cycle. If the flag is being set in the same cycle as the clear, the set wins.
- R9: An irqSet pulse makes irqFlag high in the next cycle, and the flag stays high until a host clear.
- R10: An irqClr pulse drops irqFlag in the next cycle, unless irqSet is high in that same cycle, in which case the flag is high afterwards.
- R11: An output request in the final cycle of a period is accepted and updates the converters, but it raises no stall, and the request counts as that period's sample.
- R12: While reset is high, stall, dacLeft, dacRight, dacStrobe, irqFlag and underrunFlag are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| outStrobe | input | 1 | Output instruction executed this cycle |
| irqSet | input | 1 | Interrupt instruction executed this cycle |
| sampleIn | input | 16 | Packed stereo sample: left in [15:8], right in [7:0] |
| irqClr | input | 1 | Host clear of the interrupt flag |
| underrunClr | input | 1 | Host clear of the underrun flag |
| stall | output | 1 | Holds the processor until the next period |
| dacLeft | output | 8 | Left converter sample |
| dacRight | output | 8 | Right converter sample |
| dacStrobe | output | 1 | One-cycle pulse when new converter values appear |
| irqFlag | output | 1 | Host interrupt flag |
| underrunFlag | output | 1 | Sticky missed-period flag |

## Verification
There are two places where a program event and a boundary event can land in the same cycle.

The first is an output request in the last cycle of a period. This request meets the period wrap that releases the stall. The bench places a request exactly on that cycle and checks three things in the next cycle: the converters are updated, stall stays low, and no underrun is recorded.

The second is an interrupt instruction that coincides with a host clear. The bench pulses both on the same cycle and expects the flag to read high afterwards.

// File: rtl/pacer_pkg.sv
package pacer_pkg;

  // Strobes from the control half to the sample datapath.
  typedef struct packed {
    logic latch;      // accepted output request this cycle
    logic periodEnd;  // final cycle of the current sample period
  } pacerCtrl_t;

endpackage

// File: rtl/pacer_ctrl.sv
module pacer_ctrl
  import pacer_pkg::*;
#(
  parameter int PERIOD = 750
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       outStrobe,
  input  logic       irqSet,
  input  logic       irqClr,
  output pacerCtrl_t ctrl,
  output logic       stall,
  output logic       irqFlag
);

  localparam int CNT_W = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [CNT_W-1:0] LAST_COUNT = CNT_W'(PERIOD - 1);

  logic [CNT_W-1:0] periodCount;
  logic             lastCycle;
  logic             accept;
  logic             stallQ;
  logic             irqQ;

  assign lastCycle = (periodCount == LAST_COUNT);
  assign accept    = outStrobe && !stallQ;

  // Free-running period counter, independent of the stall.
  always_ff @(posedge clk) begin
    if (rst)            periodCount <= '0;
    else if (lastCycle) periodCount <= '0;
    else                periodCount <= periodCount + 1'b1;
  end

  // Stall: set by an accepted output, released at the period wrap.
  always_ff @(posedge clk) begin
    if (rst)            stallQ <= 1'b0;
    else if (lastCycle) stallQ <= 1'b0;
    else if (accept)    stallQ <= 1'b1;
  end

  // Interrupt flag: the program sets it, the host clears it, and a set wins.
  always_ff @(posedge clk) begin
    if (rst)         irqQ <= 1'b0;
    else if (irqSet) irqQ <= 1'b1;
    else if (irqClr) irqQ <= 1'b0;
  end

  always_comb begin
    ctrl           = '0;
    ctrl.latch     = accept;
    ctrl.periodEnd = lastCycle;
  end

  assign stall   = stallQ;
  assign irqFlag = irqQ;

endmodule

// File: rtl/pacer_datapath.sv
module pacer_datapath
  import pacer_pkg::*;
#(
  parameter int HALF_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  pacerCtrl_t            ctrl,
  input  logic [2*HALF_W-1:0]   sampleIn,
  input  logic                  underrunClr,
  output logic [HALF_W-1:0]     dacLeft,
  output logic [HALF_W-1:0]     dacRight,
  output logic                  dacStrobe,
  output logic                  underrunFlag
);

  logic [HALF_W-1:0] leftQ;
  logic [HALF_W-1:0] rightQ;
  logic              strobeQ;
  logic              emittedQ;
  logic              underrunQ;
  logic              missedPeriod;

  // Converter registers change only on an accepted output.
  always_ff @(posedge clk) begin
    if (rst) begin
      leftQ  <= '0;
      rightQ <= '0;
    end else if (ctrl.latch) begin
      leftQ  <= sampleIn[2*HALF_W-1:HALF_W];
      rightQ <= sampleIn[HALF_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) strobeQ <= 1'b0;
    else     strobeQ <= ctrl.latch;
  end

  // Tracks whether the current period has delivered a sample.
  always_ff @(posedge clk) begin
    if (rst)                 emittedQ <= 1'b0;
    else if (ctrl.periodEnd) emittedQ <= 1'b0;
    else if (ctrl.latch)     emittedQ <= 1'b1;
  end

  assign missedPeriod = ctrl.periodEnd && !(emittedQ || ctrl.latch);

  always_ff @(posedge clk) begin
    if (rst)               underrunQ <= 1'b0;
    else if (missedPeriod) underrunQ <= 1'b1;
    else if (underrunClr)  underrunQ <= 1'b0;
  end

  assign dacLeft      = leftQ;
  assign dacRight     = rightQ;
  assign dacStrobe    = strobeQ;
  assign underrunFlag = underrunQ;

endmodule

// File: rtl/sample_pacer.sv
module sample_pacer
  import pacer_pkg::*;
#(
  parameter int PERIOD = 750,
  parameter int HALF_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                outStrobe,
  input  logic                irqSet,
  input  logic [2*HALF_W-1:0] sampleIn,
  input  logic                irqClr,
  input  logic                underrunClr,
  output logic                stall,
  output logic [HALF_W-1:0]   dacLeft,
  output logic [HALF_W-1:0]   dacRight,
  output logic                dacStrobe,
  output logic                irqFlag,
  output logic                underrunFlag
);

  pacerCtrl_t ctrlBus;

  pacer_ctrl #(.PERIOD(PERIOD)) uCtrl (
    .clk       (clk),
    .rst       (rst),
    .outStrobe (outStrobe),
    .irqSet    (irqSet),
    .irqClr    (irqClr),
    .ctrl      (ctrlBus),
    .stall     (stall),
    .irqFlag   (irqFlag)
  );

  pacer_datapath #(.HALF_W(HALF_W)) uData (
    .clk          (clk),
    .rst          (rst),
    .ctrl         (ctrlBus),
    .sampleIn     (sampleIn),
    .underrunClr  (underrunClr),
    .dacLeft      (dacLeft),
    .dacRight     (dacRight),
    .dacStrobe    (dacStrobe),
    .underrunFlag (underrunFlag)
  );

endmodule

// File: rtl/pacer_checker.sv
module pacer_checker #(
  parameter int HALF_W = 8
) (
  input logic                clk,
  input logic                rst,
  input logic                outStrobe,
  input logic                irqSet,
  input logic                irqClr,
  input logic                underrunClr,
  input logic                stall,
  input logic [HALF_W-1:0]   dacLeft,
  input logic [HALF_W-1:0]   dacRight,
  input logic                dacStrobe,
  input logic                irqFlag,
  input logic                underrunFlag
);

  // R2
  accept_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    (outStrobe && !stall) |=> dacStrobe);

  // R3
  dac_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !dacStrobe |-> ($stable(dacLeft) && $stable(dacRight)));

  // R6
  stalled_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (stall && outStrobe) |=> !dacStrobe);

  // R4
  stall_cause_chk: assert property (@(posedge clk) disable iff (rst)
    (!stall && !outStrobe) |=> !stall);

  // R9
  irq_set_chk: assert property (@(posedge clk) disable iff (rst)
    irqSet |=> irqFlag);

  // R10
  irq_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (irqClr && !irqSet) |=> !irqFlag);

  // R9
  irq_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (irqFlag && !irqClr) |=> irqFlag);

  // R8
  underrun_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (underrunFlag && !underrunClr) |=> underrunFlag);

  // R12
  always @(negedge clk) begin
    if (rst) begin
      reset_state_chk: assert (!stall && !dacStrobe && !irqFlag && !underrunFlag
                               && dacLeft == '0 && dacRight == '0);
    end
  end

endmodule

bind sample_pacer pacer_checker #(.HALF_W(HALF_W)) uChk (
  .clk          (clk),
  .rst          (rst),
  .outStrobe    (outStrobe),
  .irqSet       (irqSet),
  .irqClr       (irqClr),
  .underrunClr  (underrunClr),
  .stall        (stall),
  .dacLeft      (dacLeft),
  .dacRight     (dacRight),
  .dacStrobe    (dacStrobe),
  .irqFlag      (irqFlag),
  .underrunFlag (underrunFlag)
);

// File: tb/sim_sample_pacer.sv
`timescale 1ns/1ps
module sim_sample_pacer;

  localparam int P = 12;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        outStrobe = 1'b0;
  logic        irqSet = 1'b0;
  logic [15:0] sampleIn = '0;
  logic        irqClr = 1'b0;
  logic        underrunClr = 1'b0;
  logic        stall;
  logic [7:0]  dacLeft;
  logic [7:0]  dacRight;
  logic        dacStrobe;
  logic        irqFlag;
  logic        underrunFlag;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  logic [15:0] expQ[$];

  always #2 clk = ~clk;

  sample_pacer #(.PERIOD(P), .HALF_W(8)) u0 (
    .clk(clk), .rst(rst), .outStrobe(outStrobe), .irqSet(irqSet),
    .sampleIn(sampleIn), .irqClr(irqClr), .underrunClr(underrunClr),
    .stall(stall), .dacLeft(dacLeft), .dacRight(dacRight),
    .dacStrobe(dacStrobe), .irqFlag(irqFlag), .underrunFlag(underrunFlag)
  );

  // Bench view of the period position (R1): cycle 0 follows reset release.
  always @(posedge clk) if (!rst) cyc <= cyc + 1;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic waitPos(input int p);
    while ((cyc % P) != p) step();
  endtask

  // Driver: issues an output request and queues the expected converter word.
  task automatic issueOut(input logic [15:0] s, input bit accepted);
    outStrobe = 1'b1;
    sampleIn  = s;
    if (accepted) expQ.push_back(s);
    step();
    outStrobe = 1'b0;
  endtask

  // Monitor: every strobe must match the oldest expected sample (R2, R3).
  always @(negedge clk) begin
    if (!rst && dacStrobe) begin
      if (expQ.size() == 0) begin
        check("R3 unexpected strobe", 1, 0);
      end else begin
        logic [15:0] e;
        e = expQ.pop_front();
        check("R2 left", dacLeft, e[15:8]);
        check("R2 right", dacRight, e[7:0]);
      end
    end
  end

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    step(); step();
    // R12 reset state
    check("R12 stall", stall, 0);
    check("R12 dac", {dacLeft, dacRight}, 0);
    check("R12 strobe", dacStrobe, 0);
    check("R12 irq", irqFlag, 0);
    check("R12 underrun", underrunFlag, 0);
    rst = 1'b0;

    // Mid-period output: R2, R3, R4
    waitPos(3);
    issueOut(16'h7F80, 1);
    check("R4 stall raised", stall, 1);
    check("R3 strobe high", dacStrobe, 1);
    step();
    check("R3 strobe one cycle", dacStrobe, 0);
    // R6 request while stalled is ignored
    waitPos(6);
    issueOut(16'h1234, 0);
    check("R6 no strobe", dacStrobe, 0);
    check("R6 dac kept", {dacLeft, dacRight}, 16'h7F80);
    waitPos(P-1);
    check("R4 stall at last cycle", stall, 1);
    step();
    check("R5 stall released", stall, 0);
    check("R1 period position", cyc % P, 0);
    check("R7 no underrun after active period", underrunFlag, 0);
    check("R6 dac kept after release", {dacLeft, dacRight}, 16'h7F80);

    // R7 idle period
    waitPos(P-1);
    step();
    check("R7 underrun set", underrunFlag, 1);
    check("R7 dac held", {dacLeft, dacRight}, 16'h7F80);
    check("R7 no stall", stall, 0);

    // R8 clear, then an active period keeps it clear
    waitPos(2);
    underrunClr = 1'b1;
    step();
    underrunClr = 1'b0;
    check("R8 underrun cleared", underrunFlag, 0);
    waitPos(4);
    issueOut(16'h01FF, 1);
    waitPos(0);
    check("R8 underrun stays clear", underrunFlag, 0);
    check("R5 release", stall, 0);

    // R11 output on the final cycle
    waitPos(P-1);
    issueOut(16'h8001, 1);
    check("R11 no stall", stall, 0);
    check("R11 strobe", dacStrobe, 1);
    check("R11 counted as sample", underrunFlag, 0);
    step();
    check("R11 still no stall", stall, 0);

    // R9 and R10 interrupt flag
    irqSet = 1'b1; step(); irqSet = 1'b0;
    check("R9 irq set", irqFlag, 1);
    step(); step();
    check("R9 irq sticky", irqFlag, 1);
    irqClr = 1'b1; step(); irqClr = 1'b0;
    check("R10 irq cleared", irqFlag, 0);
    irqSet = 1'b1; irqClr = 1'b1; step();
    irqSet = 1'b0; irqClr = 1'b0;
    check("R10 set wins over clear", irqFlag, 1);
    irqClr = 1'b1; step(); irqClr = 1'b0;
    check("R10 final clear", irqFlag, 0);

    step(); step();
    check("R3 all strobes seen", expQ.size(), 0);
    summary();
    $finish;
  end

endmodule